// File: doc/BRIEF.md
# Dual-Rail Configurable Two-Operand Logic Unit

This block evaluates any one of the sixteen Boolean functions of two operands. Each operand and the result travels as a two-wire code. One wire pair stands for "nothing yet", one for a logic zero and one for a logic one; the fourth pattern is illegal. A configuration word is written while the unit is idle. It holds, for each of the four operand combinations, the exact output code to produce, so the function is set by eight rail-level switches rather than by a bare four-bit table.

The unit is modelled as clocked logic. It stays silent until both operands carry legal data, then registers the selected result one clock later. It goes silent again as soon as either operand returns to "nothing". If an illegal pattern appears on an operand, a sticky error is raised and the output is held silent until reset. A configuration word whose switch pairs are not each one-hot is reported, and such a word never produces output.

Top module: `dr_logic_unit`

## Requirements
- R1: Every two-wire signal uses 00 = no data, 01 = logic 0, 10 = logic 1, and 11 = illegal. The output `outZ` never shows 11.
- R2: Configuration bits [2i+1:2i] hold the output code for operand index i = {A bit, B bit}: index 0 is A=0,B=0 and index 3 is A=1,B=1. AND is therefore 8'h95. Any of the 16 functions can be set this way.
- R3: When both operands hold legal data (01 or 10) on a clock edge, `outZ` shows the configured code for that index after that edge. If only one operand holds data, `outZ` is 00.
- R4: If either operand is 00 on a clock edge, `outZ` is 00 after that edge.
- R5: A configuration write (`cfgLoad` high) takes effect on the edge only when both operands are 00. A write attempted while data is present is ignored, and the previous function stays in force.
- R6: If any switch pair in the stored configuration is 00 or 11, `cfgBad` is high and `outZ` stays 00 for any operands.
- R7: An 11 on either operand at a clock edge sets `codeErr` after that edge. `codeErr` stays set until reset. While it is set, `outZ` is 00.
- R8: Reset (active low, asynchronous) clears `outZ` to 00 and `codeErr` to 0. It also loads the constant-zero function (8'h55), so `cfgBad` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Configuration write strobe |
| cfgWord | input | 8 | Eight rail-level switches, two per operand index |
| inA | input | 2 | Operand A, two-wire code |
| inB | input | 2 | Operand B, two-wire code |
| outZ | output | 2 | Result, two-wire code |
| cfgBad | output | 1 | Stored configuration is not one-hot per pair |
| codeErr | output | 1 | Sticky flag: an illegal operand code was seen |

## Verification
The bench sweeps all sixteen functions over every legal operand pair and checks each result against a truth table held in the bench. A swapped index order or a swapped rail pair would fail this sweep.

Directed cases cover the corners:
- A single operand holding data must not produce output; an early-firing design would emit a result there.
- A configuration write made while data is present must leave the old function in force; a design that ignores the rule would switch functions mid-operation.
- Configurations with a 00 or 11 pair must be reported and stay silent; a careless design would emit an illegal output code.
- An illegal operand code must latch the error and block output until reset; a non-sticky design would resume output early.

Random operand sequences, with returns to no-data between them, check that the output returns to silence every time.

// File: rtl/drlu_pkg.sv
package drlu_pkg;
  localparam int IN_CNT    = 2;
  localparam int ENTRY_CNT = 1 << IN_CNT;
  localparam int CFG_W     = 2 * ENTRY_CNT;
  localparam int IDX_W     = IN_CNT;

  typedef enum logic [1:0] {
    RAIL_NULL = 2'b00,
    RAIL_ZERO = 2'b01,
    RAIL_ONE  = 2'b10,
    RAIL_BAD  = 2'b11
  } railCode_t;

  // Reset function: every entry yields logic 0.
  localparam logic [CFG_W-1:0] CFG_RESET = {ENTRY_CNT{RAIL_ZERO}};

  typedef struct packed {
    logic             cfgCapture;
    logic             fire;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;
endpackage

// File: rtl/drlu_ctrl.sv
module drlu_ctrl
  import drlu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgLoad,
  input  logic      cfgOk,
  input  logic [1:0] inA,
  input  logic [1:0] inB,
  output dpStrobe_t strobe,
  output logic      codeErr
);
  logic [IN_CNT-1:0][1:0] railsIn;
  logic [IN_CNT-1:0]      isValid;
  logic [IN_CNT-1:0]      isNull;
  logic [IN_CNT-1:0]      isBad;
  logic [IN_CNT-1:0]      bitVal;
  logic                   allValid;
  logic                   allNull;
  logic                   anyBad;
  logic                   errSticky;

  // Index order: operand A is the upper bit, B the lower bit.
  assign railsIn = {inA, inB};

  for (genvar k = 0; k < IN_CNT; k++) begin : g_decode
    assign isValid[k] = railsIn[k] == RAIL_ZERO || railsIn[k] == RAIL_ONE;
    assign isNull[k]  = railsIn[k] == RAIL_NULL;
    assign isBad[k]   = railsIn[k] == RAIL_BAD;
    assign bitVal[k]  = railsIn[k] == RAIL_ONE;
  end

  assign allValid = &isValid;
  assign allNull  = &isNull;
  assign anyBad   = |isBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errSticky <= 1'b0;
    else if (anyBad) errSticky <= 1'b1;
  end

  always_comb begin
    strobe            = '0;
    strobe.cfgCapture = cfgLoad && allNull;
    strobe.fire       = allValid && !anyBad && !errSticky && cfgOk;
    strobe.idx        = bitVal;
  end

  assign codeErr = errSticky;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |=> codeErr); // R7
  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (inA == 2'b11 || inB == 2'b11) |=> codeErr); // R7
endmodule

// File: rtl/drlu_datapath.sv
module drlu_datapath
  import drlu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CFG_W-1:0] cfgWord,
  output logic [1:0]       outZ,
  output logic             cfgOk
);
  logic [CFG_W-1:0]         cfgReg;
  logic [ENTRY_CNT-1:0][1:0] entryCode;
  logic [ENTRY_CNT-1:0]     entryOk;
  logic [1:0]               outNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= CFG_RESET;
    else if (strobe.cfgCapture) cfgReg <= cfgWord;
  end

  for (genvar e = 0; e < ENTRY_CNT; e++) begin : g_entry
    assign entryCode[e] = cfgReg[2*e +: 2];
    assign entryOk[e]   = entryCode[e] == RAIL_ZERO || entryCode[e] == RAIL_ONE;
  end

  assign cfgOk   = &entryOk;
  assign outNext = strobe.fire ? entryCode[strobe.idx] : RAIL_NULL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outZ <= RAIL_NULL;
    else outZ <= outNext;
  end

  AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outZ != 2'b11); // R1
endmodule

// File: rtl/dr_logic_unit.sv
module dr_logic_unit
  import drlu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [1:0]       inA,
  input  logic [1:0]       inB,
  output logic [1:0]       outZ,
  output logic             cfgBad,
  output logic             codeErr
);
  dpStrobe_t strobe;
  logic      cfgOk;

  drlu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgLoad (cfgLoad),
    .cfgOk   (cfgOk),
    .inA     (inA),
    .inB     (inB),
    .strobe  (strobe),
    .codeErr (codeErr)
  );

  drlu_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgWord (cfgWord),
    .outZ    (outZ),
    .cfgOk   (cfgOk)
  );

  assign cfgBad = !cfgOk;

  AST_NULL_GIVES_NULL: assert property (@(posedge clk) disable iff (!rstN)
    (inA == 2'b00 || inB == 2'b00) |=> outZ == 2'b00); // R4
  AST_BAD_CFG_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cfgBad |=> outZ == 2'b00); // R6
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> outZ == 2'b00); // R7
  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (inA != 2'b00 || inB != 2'b00) |=> $stable(u_dp.cfgReg)); // R5
endmodule

// File: tb/dr_logic_unit_tb.sv
module dr_logic_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [7:0] cfgWord = 8'h00;
  logic [1:0] inA = 2'b00;
  logic [1:0] inB = 2'b00;
  logic [1:0] outZ;
  logic       cfgBad;
  logic       codeErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dr_logic_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgWord(cfgWord),
    .inA(inA), .inB(inB), .outZ(outZ), .cfgBad(cfgBad), .codeErr(codeErr)
  );

  // Truth table tt[i] = result for index i = {a,b}; build switch word.
  function automatic logic [7:0] cfgOf(input logic [3:0] tt);
    logic [7:0] w;
    for (int i = 0; i < 4; i++) w[2*i +: 2] = tt[i] ? 2'b10 : 2'b01;
    return w;
  endfunction

  function automatic logic [1:0] enc(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic [1:0] b);
    inA = a; inB = b;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic loadCfg(input logic [7:0] w);
    inA = 2'b00; inB = 2'b00; cfgLoad = 1'b1; cfgWord = w;
    @(posedge clk); @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgLoad = 1'b0; inA = 2'b00; inB = 2'b00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [3:0] tt;
    void'($urandom(32'd4242));
    doReset();
    // R8 reset state
    check("R8 outZ", outZ, 2'b00);
    check("R8 codeErr", codeErr, 1'b0);
    check("R8 cfgBad", cfgBad, 1'b0);
    step(2'b10, 2'b10);
    check("R8 const-zero function", outZ, 2'b01);
    step(2'b00, 2'b00);

    // R2 R3 full sweep of all 16 functions
    for (int f = 0; f < 16; f++) begin
      loadCfg(cfgOf(f[3:0]));
      for (int i = 0; i < 4; i++) begin
        step(enc(i[1]), enc(i[0]));
        check("R2 sweep", outZ, enc(f[i]));
        step(2'b00, 2'b00);
        check("R4 null after sweep", outZ, 2'b00);
      end
    end

    // R2 AND pattern
    loadCfg(8'h95);
    step(2'b10, 2'b10); check("R2 AND 1,1", outZ, 2'b10);
    step(2'b01, 2'b10); check("R2 AND 0,1", outZ, 2'b01);

    // R3 half valid, R4 return to null with one operand
    step(2'b00, 2'b10); check("R3 only B valid", outZ, 2'b00);
    step(2'b10, 2'b00); check("R3 only A valid", outZ, 2'b00);
    step(2'b10, 2'b10); check("R3 both valid", outZ, 2'b10);
    step(2'b10, 2'b00); check("R4 B returns null", outZ, 2'b00);
    step(2'b00, 2'b00);

    // R5 write while data present is ignored
    inA = 2'b10; inB = 2'b10; cfgLoad = 1'b1; cfgWord = 8'h55;
    @(posedge clk); @(negedge clk);
    cfgLoad = 1'b0;
    step(2'b10, 2'b10); check("R5 busy write ignored", outZ, 2'b10);
    step(2'b00, 2'b00);

    // R6 malformed configurations
    loadCfg(8'h54);
    check("R6 pair 00 flagged", cfgBad, 1'b1);
    step(2'b01, 2'b01); check("R6 silent on 00 pair", outZ, 2'b00);
    step(2'b00, 2'b00);
    loadCfg(8'hD5);
    check("R6 pair 11 flagged", cfgBad, 1'b1);
    step(2'b10, 2'b10); check("R6 silent on 11 pair", outZ, 2'b00);
    step(2'b00, 2'b00);
    loadCfg(8'h95);
    check("R6 valid clears flag", cfgBad, 1'b0);

    // Random operand runs with random functions
    for (int n = 0; n < 300; n++) begin
      logic a, b;
      if (n % 20 == 0) begin
        tt = 4'($urandom);
        loadCfg(cfgOf(tt));
      end
      a = 1'($urandom); b = 1'($urandom);
      step(enc(a), enc(b));
      check("R3 random", outZ, enc(tt[{a, b}]));
      step(2'b00, 2'b00);
      check("R4 random null", outZ, 2'b00);
    end

    // R7 illegal operand code, sticky until reset
    loadCfg(8'h95);
    step(2'b11, 2'b10);
    check("R7 err set", codeErr, 1'b1);
    check("R7 out null on bad", outZ, 2'b00);
    step(2'b10, 2'b10);
    check("R7 out blocked", outZ, 2'b00);
    check("R1 output legal", outZ == 2'b11, 1'b0);
    step(2'b00, 2'b00);
    check("R7 err sticky", codeErr, 1'b1);
    doReset();
    check("R8 err cleared", codeErr, 1'b0);
    step(2'b10, 2'b01);
    check("R8 const-zero after reset", outZ, 2'b01);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule